// File: doc/BRIEF.md
# Mode-Selectable Fan Tachometer Monitor

This block measures how fast a fan turns. It counts reference clock cycles between consecutive rising edges of the fan's tach signal and stores the count as a 16-bit reading. A 2-bit mode input selects what happens when the fan is too slow to measure. In the raw mode the counter wraps. In the saturating mode the reading clamps to all ones. The two extended modes also clamp, and they cover a wider low-speed range by counting only while the fan's PWM drive is on.

A 3-bit PWM frequency code sets the slowest speed that can be measured. The block turns this speed into a maximum period count using a lookup computed at elaboration from the `RPM_SCALE` parameter. `RPM_SCALE` is the number of reference cycles per minute divided by the tach pulses per revolution, so the count limit is `RPM_SCALE / rpm`. After each complete period the block writes the reading and the below-minimum flag, and raises a one-cycle update strobe.

Top module: `fan_tach_monitor`

## Requirements
- R1: While reset is asserted, and after it until the first update, `reading` is 16'hFFFF, `below_min` is 1 and `update` is 0.
- R2: The first accepted rising edge after reset, or after any change of `tach_mode` or `pwm_code`, only starts a period and produces no update. An edge in the same cycle as a configuration change also produces no update.
- R3: In mode 2'b00 (raw), each accepted rising edge after the first writes the number of cycles since the previous edge, modulo 2^16, into `reading`, and clears `below_min`, whatever the speed.
- R4: In mode 2'b01 (saturating), a period count below the limit is written as is with `below_min` = 0. A count at or above the limit writes 16'hFFFF with `below_min` = 1.
- R5: In modes 2'b00 and 2'b01 the limit is floor(RPM_SCALE / rpm). For `pwm_code` 0 to 7 the rpm values are 1262, 1944, 2523, 3205, 3953, 5156, 7906 and 841.
- R6: In modes 2'b10 and 2'b11 (extended) the saturation rule of R4 applies. The rpm values are 210 for code 0, 315 for code 1 and 420 for codes 2 to 7.
- R7: In the extended modes, the period counter does not advance in cycles where `pwm_on` is 0.
- R8: In the extended modes, a tach rising edge that is detected while `pwm_on` is 0 is ignored.
- R9: In modes 2'b00 and 2'b01, `pwm_on` has no effect on the count.
- R10: `update` is a single-cycle pulse in the cycle after the closing edge is detected. `reading` and `below_min` change only in a cycle where `update` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw fan tach signal, asynchronous |
| pwm_on | input | 1 | Current state of the fan PWM drive, 1 = on |
| tach_mode | input | 2 | Measurement mode, 00 raw, 01 saturating, 10/11 extended |
| pwm_code | input | 3 | PWM frequency code that selects the limit |
| reading | output | CNT_W | Last period count, or all ones when below minimum |
| below_min | output | 1 | Last period was at or above the count limit |
| update | output | 1 | One-cycle strobe marking a new reading |

## Verification
The checker covers the properties that hold on every cycle. These are the reset values, the rule that the reading and flag change only alongside the strobe, the strobe lasting a single cycle, and the agreement between the flag and the all-ones reading in the clamping modes. Other behaviour depends on whole periods of stimulus, and only the scenarios show it. This covers the exact counts against each limit, one below and at each boundary, the wrap in raw mode, the paused counter and the ignored glitch during PWM off-time, the indifference of the conventional modes to PWM, and the re-arming after a configuration change.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

   localparam int unsigned CODE_W    = 3;
   localparam int unsigned NUM_CODES = 1 << CODE_W;

   typedef enum logic [1:0] {
      TM_RAW     = 2'b00,
      TM_SAT     = 2'b01,
      TM_EXT_ACC = 2'b10,
      TM_EXT_LOW = 2'b11
   } tach_mode_e;

   // Slowest measurable fan speed for a frequency code and mode family.
   function automatic int unsigned min_rpm(input int unsigned code, input bit ext);
      int unsigned r;
      if (ext) begin
         case (code)
            0:       r = 210;
            1:       r = 315;
            default: r = 420;
         endcase
      end else begin
         case (code)
            0:       r = 1262;
            1:       r = 1944;
            2:       r = 2523;
            3:       r = 3205;
            4:       r = 3953;
            5:       r = 5156;
            6:       r = 7906;
            default: r = 841;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic rise
);
   localparam int unsigned LAST = STAGES;

   logic [LAST:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("tach_edge_sync: STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[LAST-1:0], raw_in};
   end

   assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/tach_limit_lut.sv
module tach_limit_lut #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned RPM_SCALE = 2_700_000
) (
   input  logic [fan_tach_pkg::CODE_W-1:0] code,
   input  logic                            ext,
   output logic [CNT_W-1:0]                limit
);
   import fan_tach_pkg::*;

   logic [CNT_W-1:0] conv_tbl [NUM_CODES];
   logic [CNT_W-1:0] ext_tbl  [NUM_CODES];

   generate
      for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
         localparam int unsigned CONV_LIM = RPM_SCALE / min_rpm(g, 1'b0);
         localparam int unsigned EXT_LIM  = RPM_SCALE / min_rpm(g, 1'b1);
         assign conv_tbl[g] = CNT_W'(CONV_LIM);
         assign ext_tbl[g]  = CNT_W'(EXT_LIM);
      end
   endgenerate

   assign limit = ext ? ext_tbl[code] : conv_tbl[code];
endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             saturate,
   output logic [CNT_W-1:0] count
);
   logic at_top;
   assign at_top = &count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (restart) begin
         count <= CNT_W'(1);
      end else if (run && !(saturate && at_top)) begin
         count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned RPM_SCALE   = 2_700_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tach_in,
   input  logic                            pwm_on,
   input  logic [1:0]                      tach_mode,
   input  logic [fan_tach_pkg::CODE_W-1:0] pwm_code,
   output logic [CNT_W-1:0]                reading,
   output logic                            below_min,
   output logic                            update
);
   import fan_tach_pkg::*;

   localparam int unsigned CFG_W   = 2 + CODE_W;
   localparam longint      CNT_MAX = (64'd1 << CNT_W) - 1;

   generate
      if (CNT_W < 8 || CNT_W > 31) begin : g_bad_width
         $error("fan_tach_monitor: CNT_W out of range");
      end
      if (longint'(RPM_SCALE / min_rpm(0, 1'b1)) > CNT_MAX) begin : g_bad_scale
         $error("fan_tach_monitor: RPM_SCALE too large for CNT_W");
      end
   endgenerate

   tach_mode_e       mode_e;
   logic             raw_mode;
   logic             ext_mode;
   logic             rise;
   logic             edge_ok;
   logic             run;
   logic             fire;
   logic             over;
   logic             armed;
   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] limit;

   assign mode_e   = tach_mode_e'(tach_mode);
   assign raw_mode = (mode_e == TM_RAW);
   assign ext_mode = (mode_e == TM_EXT_ACC) || (mode_e == TM_EXT_LOW);
   assign cfg_now  = {tach_mode, pwm_code};
   assign cfg_chg  = (cfg_now != cfg_q);

   tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (tach_in),
      .rise   (rise)
   );

   tach_limit_lut #(.CNT_W(CNT_W), .RPM_SCALE(RPM_SCALE)) u_lut (
      .code  (pwm_code),
      .ext   (ext_mode),
      .limit (limit)
   );

   // Extended modes: only edges and cycles with the drive on count.
   assign run     = ~ext_mode | pwm_on;
   assign edge_ok = rise & run;

   tach_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (edge_ok),
      .run      (run),
      .saturate (~raw_mode),
      .count    (count)
   );

   assign over = (count >= limit);
   assign fire = edge_ok & armed & ~cfg_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         armed     <= 1'b0;
         reading   <= '1;
         below_min <= 1'b1;
         update    <= 1'b0;
      end else begin
         cfg_q  <= cfg_now;
         update <= fire;
         if (cfg_chg)      armed <= 1'b0;
         else if (edge_ok) armed <= 1'b1;
         if (fire) begin
            reading   <= (!raw_mode && over) ? '1 : count;
            below_min <= !raw_mode && over;
         end
      end
   end
endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       tach_mode,
   input logic [CNT_W-1:0] reading,
   input logic             below_min,
   input logic             update
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (reading == '1 && below_min && !update));

   // R10
   reading_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reading != $past(reading) || below_min != $past(below_min)) |-> update);

   // R10
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> !update);

   // R4
   flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update && $past(tach_mode) != 2'b00) |-> (below_min == (reading == '1)));

   // R3
   raw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update && $past(tach_mode) == 2'b00) |-> !below_min);
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tach_mode (tach_mode),
   .reading   (reading),
   .below_min (below_min),
   .update    (update)
);

// File: tb/fan_tach_monitor_test.sv
module fan_tach_monitor_test;
   localparam int unsigned SCALE = 420_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tach_in = 1'b0;
   logic        pwm_on = 1'b1;
   logic [1:0]  tach_mode = 2'b00;
   logic [2:0]  pwm_code = 3'd0;
   logic [15:0] reading;
   logic        below_min;
   logic        update;

   int tests = 0;
   int fails = 0;
   int hold_viol = 0;
   logic        monitor_on = 1'b0;
   logic [15:0] prev_reading = 16'hFFFF;
   logic        prev_flag = 1'b1;

   logic [15:0] q_val [$];
   logic        q_flag [$];
   string       q_tag [$];

   always #10 clk = ~clk;

   fan_tach_monitor #(.CNT_W(16), .RPM_SCALE(SCALE), .SYNC_STAGES(2)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tach_in   (tach_in),
      .pwm_on    (pwm_on),
      .tach_mode (tach_mode),
      .pwm_code  (pwm_code),
      .reading   (reading),
      .below_min (below_min),
      .update    (update)
   );

   function automatic int lim_of(int m, int c);
      int conv [8] = '{1262, 1944, 2523, 3205, 3953, 5156, 7906, 841};
      int extd [8] = '{210, 315, 420, 420, 420, 420, 420, 420};
      return (m >= 2) ? SCALE / extd[c] : SCALE / conv[c];
   endfunction

   // Monitor: pops the scoreboard on every strobe.
   always @(negedge clk) begin
      if (monitor_on) begin
         if (update) begin
            tests++;
            if (q_val.size() == 0) begin
               fails++;
               $display("FAIL R2 unexpected update: reading=%h expected no update", reading);
            end else begin
               logic [15:0] ev;
               logic        ef;
               string       et;
               ev = q_val.pop_front();
               ef = q_flag.pop_front();
               et = q_tag.pop_front();
               if (reading !== ev || below_min !== ef) begin
                  fails++;
                  $display("FAIL %s reading=%h flag=%b expected reading=%h flag=%b",
                           et, reading, below_min, ev, ef);
               end
            end
         end else if (reading !== prev_reading || below_min !== prev_flag) begin
            hold_viol++;
         end
         prev_reading = reading;
         prev_flag    = below_min;
      end
   end

   task automatic set_cfg(int m, int c);
      @(negedge clk);
      tach_mode = 2'(m);
      pwm_code  = 3'(c);
      tach_in   = 1'b0;
      pwm_on    = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // Driver: pushes the expected item, then drives one full period.
   task automatic period(int m, int c, int p, int gap, bit glitch, string tag);
      int cnt;
      int lim;
      cnt = (m >= 2) ? p - gap : p;
      lim = lim_of(m, c);
      if (m == 0) begin
         q_val.push_back(16'(cnt % 65536));
         q_flag.push_back(1'b0);
      end else if (cnt >= lim) begin
         q_val.push_back(16'hFFFF);
         q_flag.push_back(1'b1);
      end else begin
         q_val.push_back(16'(cnt));
         q_flag.push_back(1'b0);
      end
      q_tag.push_back(tag);
      for (int i = 0; i < p; i++) begin
         @(negedge clk);
         tach_in = (i < p / 2);
         pwm_on  = !(gap > 0 && i >= p / 2 + 10 && i < p / 2 + 10 + gap);
         if (glitch && i >= p / 2 + 15 && i < p / 2 + 18) tach_in = 1'b1;
      end
   endtask

   task automatic close_block();
      @(negedge clk);
      tach_in = 1'b1;
      pwm_on  = 1'b1;
      repeat (4) @(negedge clk);
      tach_in = 1'b0;
      repeat (10) @(negedge clk);
      tests++;
      if (q_val.size() != 0) begin
         fails++;
         $display("FAIL R2 pending items=%0d expected 0", q_val.size());
         q_val.delete();
         q_flag.delete();
         q_tag.delete();
      end
   endtask

   task automatic finish_run();
      tests++;
      if (hold_viol != 0) begin
         fails++;
         $display("FAIL R10 reading changed without update %0d times, expected 0", hold_viol);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      tests++;
      if (reading !== 16'hFFFF || below_min !== 1'b1 || update !== 1'b0) begin
         fails++;
         $display("FAIL R1 in reset reading=%h flag=%b update=%b expected FFFF 1 0",
                  reading, below_min, update);
      end
      rst_n = 1'b1;
      monitor_on = 1'b1;
      repeat (4) @(negedge clk);
      tests++;
      if (reading !== 16'hFFFF || below_min !== 1'b1 || update !== 1'b0) begin
         fails++;
         $display("FAIL R1 after reset reading=%h flag=%b update=%b expected FFFF 1 0",
                  reading, below_min, update);
      end

      // R4 R5: saturating mode, code 0, limit 332
      set_cfg(1, 0);
      period(1, 0, 200, 0, 0, "R4 mode1 fast");
      period(1, 0, 331, 0, 0, "R4 mode1 one below limit");
      period(1, 0, 332, 0, 0, "R4 mode1 at limit");
      period(1, 0, 500, 0, 0, "R4 mode1 slow");
      close_block();

      // R5: code 7 limit 499, code 6 limit 53, code 3 limit 131
      set_cfg(1, 7);
      period(1, 7, 498, 0, 0, "R5 code7 below");
      period(1, 7, 499, 0, 0, "R5 code7 at limit");
      close_block();
      set_cfg(1, 6);
      period(1, 6, 52, 0, 0, "R5 code6 below");
      period(1, 6, 53, 0, 0, "R5 code6 at limit");
      close_block();
      set_cfg(1, 3);
      period(1, 3, 130, 0, 0, "R5 code3 below");
      period(1, 3, 131, 0, 0, "R5 code3 at limit");
      period(1, 3, 300, 40, 0, "R9 mode1 pwm gap ignored");
      close_block();

      // R3 R9: raw mode ignores limit and pwm
      set_cfg(0, 0);
      period(0, 0, 300, 40, 0, "R9 mode0 pwm gap ignored");
      period(0, 0, 500, 0, 0, "R3 mode0 above limit raw");
      close_block();

      // R6: extended limits 2000 / 1333 / 1000
      set_cfg(2, 0);
      period(2, 0, 1999, 0, 0, "R6 mode2 code0 below");
      period(2, 0, 2000, 0, 0, "R6 mode2 code0 at limit");
      close_block();
      set_cfg(2, 1);
      period(2, 1, 1332, 0, 0, "R6 mode2 code1 below");
      period(2, 1, 1333, 0, 0, "R6 mode2 code1 at limit");
      close_block();

      // R7 R8: paused counter and ignored glitch during off-time
      set_cfg(3, 2);
      period(3, 2, 600, 40, 1, "R7 R8 mode3 gap with glitch");
      period(3, 2, 999, 0, 0, "R6 mode3 code2 below");
      period(3, 2, 1000, 0, 0, "R6 mode3 code2 at limit");
      period(3, 2, 1030, 40, 0, "R7 mode3 gap brings count below limit");
      close_block();
      set_cfg(3, 7);
      period(3, 7, 1000, 0, 0, "R6 mode3 code7 at limit");
      close_block();

      // R3: wrap in raw mode
      set_cfg(0, 3);
      period(0, 3, 65636, 0, 0, "R3 mode0 wrapped count");
      close_block();

      finish_run();
   end
endmodule